// File: doc/BRIEF.md
# Word-Aligned Inbound DMA with Edge Fragment Capture

This block is the write side of a device-to-memory DMA channel whose memory port only accepts whole, aligned 32-bit words. A transfer begins with a start pulse that carries a byte address, which need not be aligned. Bytes then arrive one per accepted cycle, and a stop pulse ends the transfer. Every aligned word that the byte stream covers completely is sent to memory as a single full-word write. The partial word at either end of the transfer is never written.

The bytes of a partial first word (the "head") go into a 32-bit head capture word. Its low byte is a valid mask and its upper three bytes hold lanes 1 to 3. The bytes of a partial last word (the "tail") go into a tail capture word. Its top byte is a valid mask and its lower three bytes hold lanes 0 to 2. At stop, a residue address register gives the aligned word that still lacks its tail. Software reads the two capture words and merges the fragments into memory itself.

Top module: `dwc_edge_capture`

## Requirements
- R1: After reset, `busy` and `wr_en` are 0, and `head_word`, `tail_word` and `resid_addr` are all zero.
- R2: A start pulse sets `busy` from the next cycle and clears both capture words. `busy` returns to 0 in the cycle after the stop is taken.
- R3: Bytes are packed little-endian. The byte accepted at byte address A goes to lane A mod 4, which is bits 8k+7:8k of `wr_data` for lane k. A full word appears with `wr_en`=1 and its aligned `wr_addr` in the cycle after its lane-3 byte is accepted.
- R4: Successive full-word writes within one transfer have addresses that increase by exactly 4.
- R5: When the start address is unaligned, the first word is not written. Lanes 1..3 of it go to `head_word` bits 31:8 at their natural positions. Bits 2:0 hold the valid mask, where bit k-1 marks lane k, and bits 7:3 are zero.
- R6: A stop taken with the byte pointer inside a word leaves that word unwritten. Lanes 0..2 of it go to `tail_word` bits 23:0. Bits 26:24 hold the valid mask, where bit 24+k marks lane k, and bits 31:27 are zero. `resid_addr` gets the aligned address of that word.
- R7: A stop taken on a word boundary leaves `tail_word` zero and sets `resid_addr` to the next byte address, which is aligned.
- R8: When an unaligned transfer starts and stops inside the same word, no write occurs. The head and tail words both hold exactly the received lanes with matching masks, and an empty transfer leaves both masks zero.
- R9: A byte offered while the channel is idle, or in the same cycle as the stop, is ignored. No write occurs and both capture words stay unchanged while idle.
- R10: A transfer that starts on an aligned address leaves `head_word` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer at `start_addr` |
| start_addr | input | AW | Byte address of the first byte |
| byte_valid | input | 1 | A device byte is offered this cycle |
| byte_data | input | 8 | Device byte |
| stop | input | 1 | End the transfer |
| busy | output | 1 | Transfer in progress |
| wr_en | output | 1 | Full-word memory write strobe |
| wr_addr | output | AW | Aligned word address of the write |
| wr_data | output | 32 | Little-endian word data |
| head_word | output | 32 | Head capture: mask in bits 2:0, lanes 1..3 above |
| tail_word | output | 32 | Tail capture: mask in bits 26:24, lanes 0..2 below |
| resid_addr | output | AW | Aligned address of the word still owed its tail |

## Verification
A wrong byte pointer shows up at the ports on the first completed word, one cycle after its fourth byte arrives. The data comes out in the wrong lanes or the write address slips off its 4-byte stride. A wrong first-word flag shows up either as an unaligned head being written to memory or as a head word that stays empty. The bench sees either fault within four bytes of the start. Errors in the mask or in the lane bounds show only at stop, in the fields of the capture words and in `resid_addr`, so every transfer ends with a comparison of all three against a model built from the byte addresses alone.

// File: rtl/dwc_pkg.sv
`timescale 1ns/1ps
package dwc_pkg;

    localparam int unsigned LANES = 4;

    typedef logic [7:0]             byte_t;
    typedef logic [LANES-1:0]       lanes_t;
    typedef logic [LANES-1:0][7:0]  word_t;

    typedef enum logic { ST_IDLE, ST_RUN } state_e;

    // Lanes k with lo <= k < hi (hi may be 4).
    function automatic lanes_t lane_span(input logic [2:0] lo, input logic [2:0] hi);
        lanes_t m;
        for (int k = 0; k < LANES; k++) begin
            m[k] = (3'(k) >= lo) && (3'(k) < hi);
        end
        return m;
    endfunction

    // Head fragment: mask in the low byte, lanes 1..3 in place.
    function automatic logic [31:0] pack_head(input word_t w, input lanes_t v);
        logic [31:0] r;
        r = '0;
        for (int k = 1; k < LANES; k++) begin
            if (v[k]) r[8*k +: 8] = w[k];
            r[k-1] = v[k];
        end
        return r;
    endfunction

    // Tail fragment: mask in the high byte, lanes 0..2 in place.
    function automatic logic [31:0] pack_tail(input word_t w, input lanes_t v);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < LANES-1; k++) begin
            if (v[k]) r[8*k +: 8] = w[k];
            r[24+k] = v[k];
        end
        return r;
    endfunction

endpackage

// File: rtl/dwc_lane_buffer.sv
`timescale 1ns/1ps
module dwc_lane_buffer
    import dwc_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          push,
    input  byte_t         push_byte,
    output logic [AW-1:0] ptr,
    output word_t         held,
    output word_t         merged,
    output logic          complete
);

    logic [1:0] lane;
    assign lane = ptr[1:0];

    always_comb begin
        merged       = held;
        merged[lane] = push_byte;
    end

    assign complete = push && !load && (lane == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= '0;
            held <= '0;
        end else if (load) begin
            ptr  <= load_addr;
            held <= '0;
        end else if (push) begin
            ptr <= ptr + AW'(1);
            if (complete) held <= '0;
            else          held[lane] <= push_byte;
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (push && !load) |=> (ptr == $past(ptr) + AW'(1))); // R3

endmodule

// File: rtl/dwc_word_writer.sv
`timescale 1ns/1ps
module dwc_word_writer
    import dwc_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  word_t         data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [31:0]   wr_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= en;
            if (en) begin
                wr_addr <= {addr[AW-1:2], 2'b00};
                wr_data <= data;
            end
        end
    end

    // Tracking of the previous write, used only by the stride check.
    logic          seen_q;
    logic [AW-1:0] last_q;
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (wr_en) begin
            seen_q <= 1'b1;
            last_q <= wr_addr;
        end
    end

    AST_WORD_STRIDE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && seen_q) |-> (wr_addr == last_q + AW'(4))); // R4

endmodule

// File: rtl/dwc_edge_regs.sv
`timescale 1ns/1ps
module dwc_edge_regs
    import dwc_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          head_en,
    input  word_t         head_src,
    input  lanes_t        head_lanes,
    input  logic          tail_en,
    input  word_t         tail_src,
    input  lanes_t        tail_lanes,
    input  logic [AW-1:0] resid_in,
    output logic [31:0]   head_word,
    output logic [31:0]   tail_word,
    output logic [AW-1:0] resid_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_word  <= '0;
            tail_word  <= '0;
            resid_addr <= '0;
        end else if (clr) begin
            head_word <= '0;
            tail_word <= '0;
        end else begin
            if (head_en) head_word <= pack_head(head_src, head_lanes);
            if (tail_en) begin
                tail_word  <= pack_tail(tail_src, tail_lanes);
                resid_addr <= resid_in;
            end
        end
    end

    logic head_done_q;
    always_ff @(posedge clk) begin
        if (rst || clr) head_done_q <= 1'b0;
        else if (head_en) head_done_q <= 1'b1;
    end

    AST_HEAD_ONCE: assert property (@(posedge clk) disable iff (rst)
        (head_en && !clr) |-> !head_done_q); // R5

endmodule

// File: rtl/dwc_edge_capture.sv
`timescale 1ns/1ps
module dwc_edge_capture
    import dwc_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          byte_valid,
    input  logic [7:0]    byte_data,
    input  logic          stop,
    output logic          busy,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [31:0]   wr_data,
    output logic [31:0]   head_word,
    output logic [31:0]   tail_word,
    output logic [AW-1:0] resid_addr
);

    state_e     state_q;
    logic       first_q;
    logic [1:0] start_lane_q;

    logic          accept, stop_now, complete;
    logic [AW-1:0] ptr;
    word_t         held, merged;
    logic [1:0]    cur_lane;
    logic          head_case;

    assign busy     = (state_q == ST_RUN);
    assign accept   = busy && byte_valid && !stop && !start;
    assign stop_now = busy && stop && !start;
    assign cur_lane = ptr[1:0];
    assign head_case = first_q && (start_lane_q != 2'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            first_q      <= 1'b0;
            start_lane_q <= 2'd0;
        end else if (start) begin
            state_q      <= ST_RUN;
            first_q      <= 1'b1;
            start_lane_q <= start_addr[1:0];
        end else if (stop_now) begin
            state_q <= ST_IDLE;
        end else if (complete) begin
            first_q <= 1'b0;
        end
    end

    dwc_lane_buffer #(.AW(AW)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .load_addr (start_addr),
        .push      (accept),
        .push_byte (byte_data),
        .ptr       (ptr),
        .held      (held),
        .merged    (merged),
        .complete  (complete)
    );

    logic   write_en;
    logic   head_en;
    word_t  head_src;
    lanes_t head_lanes;
    lanes_t tail_lanes;
    logic [2:0] tail_lo;

    assign write_en = complete && !head_case;
    assign head_en  = head_case && (complete || stop_now);
    assign head_src = complete ? merged : held;
    assign head_lanes = complete ? lane_span({1'b0, start_lane_q}, 3'd4)
                                 : lane_span({1'b0, start_lane_q}, {1'b0, cur_lane});
    assign tail_lo    = head_case ? {1'b0, start_lane_q} : 3'd0;
    assign tail_lanes = lane_span(tail_lo, {1'b0, cur_lane});

    dwc_word_writer #(.AW(AW)) u_wr (
        .clk     (clk),
        .rst     (rst),
        .clr     (start),
        .en      (write_en),
        .addr    (ptr),
        .data    (merged),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    dwc_edge_regs #(.AW(AW)) u_edge (
        .clk        (clk),
        .rst        (rst),
        .clr        (start),
        .head_en    (head_en),
        .head_src   (head_src),
        .head_lanes (head_lanes),
        .tail_en    (stop_now),
        .tail_src   (held),
        .tail_lanes (tail_lanes),
        .resid_in   ({ptr[AW-1:2], 2'b00}),
        .head_word  (head_word),
        .tail_word  (tail_word),
        .resid_addr (resid_addr)
    );

    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(busy && byte_valid)); // R9

    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
        start |=> (head_word == 32'd0) && (tail_word == 32'd0) && busy); // R2

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(head_word) && $stable(tail_word) && !wr_en); // R9

endmodule

// File: tb/dwc_edge_capture_bench.sv
`timescale 1ns/1ps
module dwc_edge_capture_bench;

    localparam int unsigned AW = 32;
    localparam time CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          stop = 1'b0;
    logic          busy, wr_en;
    logic [AW-1:0] wr_addr, resid_addr;
    logic [31:0]   wr_data, head_word, tail_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    dwc_edge_capture #(.AW(AW)) u_dwc_edge_capture (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .stop       (stop),
        .busy       (busy),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .head_word  (head_word),
        .tail_word  (tail_word),
        .resid_addr (resid_addr)
    );

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_q[$];

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: every write must match the head of the scoreboard.
    always @(negedge clk) begin
        if (!rst && wr_en) begin
            if (exp_q.size() == 0) begin
                check("R9", "unexpected write", {wr_addr, wr_data}, 64'd0);
            end else begin
                logic [63:0] item;
                item = exp_q.pop_front();
                check("R3", "write addr/data", {wr_addr, wr_data}, item);
            end
        end
    end

    task automatic xfer(input logic [AW-1:0] addr, input int n, input logic [7:0] seed,
                        input bit gaps, input bit stop_byte, input string req);
        logic [AW-1:0] fin, w0, e0;
        logic [31:0]   eh, et, wd;
        fin = addr + AW'(n);
        w0  = {addr[AW-1:2], 2'b00};
        e0  = {fin[AW-1:2], 2'b00};
        eh  = '0;
        et  = '0;
        if (addr[1:0] != 2'd0) begin
            for (int l = addr[1:0]; l < 4; l++) begin
                if (w0 + AW'(l) < fin) begin
                    eh[8*l +: 8] = seed + 8'(w0 + AW'(l) - addr);
                    eh[l-1] = 1'b1;
                end
            end
        end
        if (fin[1:0] != 2'd0) begin
            for (int l = 0; l < int'(fin[1:0]); l++) begin
                if (e0 + AW'(l) >= addr) begin
                    et[8*l +: 8] = seed + 8'(e0 + AW'(l) - addr);
                    et[24+l] = 1'b1;
                end
            end
        end
        for (logic [AW-1:0] w = (addr + 3) & ~AW'(3); w + 4 <= fin; w += 4) begin
            for (int l = 0; l < 4; l++) wd[8*l +: 8] = seed + 8'(w + AW'(l) - addr);
            exp_q.push_back({w, wd});
        end

        @(posedge clk); #1;
        start = 1'b1; start_addr = addr;
        @(posedge clk); #1;
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_valid = 1'b1; byte_data = seed + 8'(i);
            @(posedge clk); #1;
            if (gaps && (i % 3 == 1)) begin
                byte_valid = 1'b0;
                @(posedge clk); #1;
            end
        end
        byte_valid = 1'b0;
        stop = 1'b1;
        if (stop_byte) begin byte_valid = 1'b1; byte_data = 8'hEE; end
        @(posedge clk); #1;
        stop = 1'b0; byte_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(req, "head_word", 64'(head_word), 64'(eh));
        check(req, "tail_word", 64'(tail_word), 64'(et));
        check(req, "resid_addr", 64'(resid_addr), 64'(e0));
        check("R2", "busy after stop", 64'(busy), 64'd0);
        check(req, "pending writes", 64'(exp_q.size()), 64'd0);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "busy", 64'(busy), 64'd0);
        check("R1", "wr_en", 64'(wr_en), 64'd0);
        check("R1", "head_word", 64'(head_word), 64'd0);
        check("R1", "tail_word", 64'(tail_word), 64'd0);
        check("R1", "resid_addr", 64'(resid_addr), 64'd0);

        xfer(32'h100, 8, 8'h10, 1'b0, 1'b0, "R4 R7 R10");   // aligned, two words
        xfer(32'h201, 10, 8'h40, 1'b0, 1'b0, "R5 R6");      // head 3 lanes, tail 3 lanes
        xfer(32'h302, 2, 8'h60, 1'b0, 1'b0, "R5 R7");       // head ends on a boundary
        xfer(32'h401, 2, 8'h70, 1'b0, 1'b0, "R8");          // same-word lanes 1,2
        xfer(32'h503, 0, 8'h80, 1'b0, 1'b0, "R8");          // empty unaligned
        xfer(32'h600, 5, 8'h90, 1'b1, 1'b0, "R6 R10");      // gaps, one tail byte
        xfer(32'h702, 7, 8'hA0, 1'b1, 1'b1, "R9");          // byte with stop ignored
        xfer(32'h801, 19, 8'hC0, 1'b1, 1'b0, "R3 R4");      // several words

        // R9: bytes while idle change nothing and cause no write
        begin
            logic [31:0] h0, t0;
            h0 = head_word; t0 = tail_word;
            @(posedge clk); #1;
            for (int i = 0; i < 5; i++) begin
                byte_valid = 1'b1; byte_data = 8'h55 + 8'(i);
                @(posedge clk); #1;
            end
            byte_valid = 1'b0;
            repeat (2) @(posedge clk);
            @(negedge clk);
            check("R9", "idle head_word", 64'(head_word), 64'(h0));
            check("R9", "idle tail_word", 64'(tail_word), 64'(t0));
            check("R9", "idle busy", 64'(busy), 64'd0);
        end

        // R2: start clears both capture words
        @(posedge clk); #1;
        start = 1'b1; start_addr = 32'h903;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        check("R2", "busy after start", 64'(busy), 64'd1);
        check("R2", "head cleared", 64'(head_word), 64'd0);
        check("R2", "tail cleared", 64'(tail_word), 64'd0);
        @(posedge clk); #1;
        stop = 1'b1;
        @(posedge clk); #1;
        stop = 1'b0;
        repeat (2) @(posedge clk);

        finish_run();
    end

endmodule